// File: doc/BRIEF.md
# Per-Line Programmable Raster Timing Generator

This block produces the raster timing for a display that runs at two pixels per clock tick. The defaults are a 420-tick line (840 pixels) and a 525-line frame. A horizontal tick counter and a vertical line counter run freely from reset. Each line takes its timing from its own entry in an internal line table. An entry sets the line's kind (blanked, vertical sync, border only, or border with an active window). It also sets the horizontal sync width, the back porch, the left and right border widths and the front porch, all in ticks. Finally it carries the memory row and start column that the scanout logic should fetch for that line.

The table has one entry per line and is filled through a simple write port. Each entry is read from the table near the end of the line before it. At the line boundary it becomes the working configuration. Because of this, porches, borders, sync width and fetch address can all change from one scanline to the next. All outputs are registered. Sync polarity is chosen by two configuration inputs. A one-tick strobe tells the scanout logic which row and column to start on, one tick before the active window opens.

Top module: `vtg_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `hsync`=!`hs_pol`, `vsync`=!`vs_pol`, `blank`=1, `border`=0, `active`=0, `line_start`=0, `ls_row`=0 and `ls_col`=0. After release the counters restart at tick 0 of the last line (index V_LINES-1), which is shown blanked with no sync. Line 0 of the table follows H_TICKS cycles later.
- R2: Every line lasts exactly H_TICKS clock cycles, with ticks numbered 0 to H_TICKS-1. Horizontal sync is asserted during ticks 0 to sync-1 of every line, whatever the line's kind.
- R3: A polarity input of 1 makes its sync output active-high and 0 makes it active-low. A change of `hs_pol` or `vs_pol` shows on the output one cycle after the edge that samples it.
- R4: On lines of kind 2'b01, vertical sync is asserted for the whole line and the line is fully blanked.
- R5: Lines of kind 2'b00 are fully blanked. On lines of kind 2'b10 and 2'b11 the visible window covers ticks sync+bp to H_TICKS-fp-1. `blank` is high exactly when neither `border` nor `active` is high.
- R6: On kind 2'b11 lines, `active` is high for ticks sync+bp+lb to H_TICKS-fp-rb-1, and `border` covers the rest of the visible window. On kind 2'b10 lines the whole visible window is border.
- R7: On kind 2'b11 lines with sync+bp+lb ≥ 1, `line_start` is a single-cycle pulse at tick sync+bp+lb-1. On other lines it stays low.
- R8: `ls_row` and `ls_col` take the row and column of the current line's entry in the cycle of the `line_start` pulse. They hold that value until the next pulse.
- R9: Line n uses table entry n. An entry is 52 bits, packed from bit 0 up: kind [1:0], sync [7:2], bp [13:8], lb [19:14], rb [25:20], fp [31:26], column [41:32], row [51:42]. Writes are accepted while `rst` is high.
- R10: The entry for a line is read at the clock edge that ends tick H_TICKS-2 of the line before it. A write at that edge or later does not affect the line about to start. It applies the next time that line is displayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per two pixels |
| rst | input | 1 | Synchronous reset, active high |
| hs_pol | input | 1 | Horizontal sync polarity, 1 = active-high |
| vs_pol | input | 1 | Vertical sync polarity, 1 = active-high |
| wr_en | input | 1 | Line table write strobe |
| wr_addr | input | $clog2(V_LINES) | Line table entry index |
| wr_data | input | 52 | Line table entry, packed as in R9 |
| hsync | output | 1 | Horizontal sync, registered |
| vsync | output | 1 | Vertical sync, registered |
| blank | output | 1 | Outside the visible window |
| border | output | 1 | Visible but outside the active window |
| active | output | 1 | Inside the active window |
| line_start | output | 1 | One tick before the active window opens |
| ls_row | output | 10 | Memory row for the current line's fetch |
| ls_col | output | 10 | Start column for the current line's fetch |

## Verification
The hardest case to reach from the ports is a table write that lands on the very edge where the next line's entry is read. The old entry must still be displayed, and the new one must appear one frame later. The stimulus tracks tick and line in the bench's own model and times one write to hit that edge exactly. Other writes go mid-frame to lines two or more ahead. The table mixes lines with zero-width sync and porches, an active window that starts at tick 0, and row and column values at their maximum.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int PW    = 6;
    localparam int ROW_W = 10;
    localparam int COL_W = 10;

    typedef enum logic [1:0] {
        K_BLANK  = 2'b00,
        K_VSYNC  = 2'b01,
        K_BORDER = 2'b10,
        K_ACTIVE = 2'b11
    } line_kind_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [PW-1:0]    fp;
        logic [PW-1:0]    rb;
        logic [PW-1:0]    lb;
        logic [PW-1:0]    bp;
        logic [PW-1:0]    sw;
        line_kind_e       kind;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

endpackage

// File: rtl/vtg_line_table.sv
module vtg_line_table
    import vtg_pkg::*;
#(
    parameter int DEPTH = 525,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  line_cfg_t       wr_data,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output line_cfg_t       rd_data
);

    line_cfg_t mem [DEPTH];
    line_cfg_t rd_q;

    // read-first: a write on the read edge is not seen by that read
    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en && (32'(rd_addr) < DEPTH)) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/vtg_raster_cnt.sv
module vtg_raster_cnt
    import vtg_pkg::*;
#(
    parameter int H_TICKS = 420,
    parameter int V_LINES = 525,
    parameter int HW      = $clog2(H_TICKS),
    parameter int VW      = $clog2(V_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  line_cfg_t     rd_data,
    output logic          rd_en,
    output logic [VW-1:0] rd_addr,
    output logic [HW-1:0] h_q,
    output logic [VW-1:0] v_q,
    output line_cfg_t     cur_q,
    output logic [HW-1:0] h_d,
    output line_cfg_t     cur_d
);

    localparam logic [HW-1:0] H_LAST  = HW'(H_TICKS - 1);
    localparam logic [HW-1:0] H_FETCH = HW'(H_TICKS - 2);
    localparam logic [VW-1:0] V_LAST  = VW'(V_LINES - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        line_cfg_t     cur;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [VW-1:0] nxt_line_d;

    always_comb begin
        st_d       = st_q;
        nxt_line_d = (st_q.v == V_LAST) ? '0 : st_q.v + VW'(1);
        rd_en      = (st_q.h == H_FETCH);
        rd_addr    = nxt_line_d;
        if (st_q.h == H_LAST) begin
            st_d.h   = '0;
            st_d.v   = nxt_line_d;
            st_d.cur = rd_data;
        end else begin
            st_d.h = st_q.h + HW'(1);
        end
        if (rst) begin
            st_d.h   = '0;
            st_d.v   = V_LAST;
            st_d.cur = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign h_q   = st_q.h;
    assign v_q   = st_q.v;
    assign cur_q = st_q.cur;
    assign h_d   = st_d.h;
    assign cur_d = st_d.cur;

endmodule

// File: rtl/vtg_flag_decode.sv
module vtg_flag_decode
    import vtg_pkg::*;
#(
    parameter int H_TICKS = 420,
    parameter int HW      = $clog2(H_TICKS)
) (
    input  logic [HW-1:0] h,
    input  line_cfg_t     cfg,
    output logic          hs_raw,
    output logic          vs_raw,
    output logic          vis,
    output logic          act,
    output logic          ls
);

    localparam int DW = ((HW > PW + 2) ? HW : PW + 2) + 1;

    logic [DW-1:0] hx_d, vis_lo_d, vis_hi_d, act_lo_d, act_hi_d;

    always_comb begin
        hx_d     = DW'(h);
        vis_lo_d = DW'(cfg.sw) + DW'(cfg.bp);
        vis_hi_d = DW'(H_TICKS) - DW'(cfg.fp);
        act_lo_d = vis_lo_d + DW'(cfg.lb);
        act_hi_d = vis_hi_d - DW'(cfg.rb);

        hs_raw = (hx_d < DW'(cfg.sw));
        vs_raw = (cfg.kind == K_VSYNC);
        vis    = cfg.kind[1] && (hx_d >= vis_lo_d) && (hx_d < vis_hi_d);
        act    = (cfg.kind == K_ACTIVE) && (hx_d >= act_lo_d) && (hx_d < act_hi_d);
        ls     = (cfg.kind == K_ACTIVE) && (act_lo_d != '0) && (hx_d == act_lo_d - DW'(1));
    end

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int H_TICKS = 420,
    parameter int V_LINES = 525
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hs_pol,
    input  logic                       vs_pol,
    input  logic                       wr_en,
    input  logic [$clog2(V_LINES)-1:0] wr_addr,
    input  logic [CFG_W-1:0]           wr_data,
    output logic                       hsync,
    output logic                       vsync,
    output logic                       blank,
    output logic                       border,
    output logic                       active,
    output logic                       line_start,
    output logic [ROW_W-1:0]           ls_row,
    output logic [COL_W-1:0]           ls_col
);

    localparam int HW = $clog2(H_TICKS);
    localparam int VW = $clog2(V_LINES);

    typedef struct packed {
        logic             hsync;
        logic             vsync;
        logic             blank;
        logic             border;
        logic             active;
        logic             ls;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } out_t;

    logic          rd_en;
    logic [VW-1:0] rd_addr;
    line_cfg_t     rd_data;
    logic [HW-1:0] h_cnt, h_nxt;
    logic [VW-1:0] v_cnt;
    line_cfg_t     cur_cfg, cur_nxt;
    logic          hs_raw, vs_raw, vis, act, ls;
    out_t          out_d, out_q;

    vtg_line_table #(.DEPTH(V_LINES), .AW(VW)) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (line_cfg_t'(wr_data)),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    vtg_raster_cnt #(.H_TICKS(H_TICKS), .V_LINES(V_LINES), .HW(HW), .VW(VW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .rd_data (rd_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .h_q     (h_cnt),
        .v_q     (v_cnt),
        .cur_q   (cur_cfg),
        .h_d     (h_nxt),
        .cur_d   (cur_nxt)
    );

    // decode the position the counters move to, so registered flags line up with them
    vtg_flag_decode #(.H_TICKS(H_TICKS), .HW(HW)) u_dec (
        .h      (h_nxt),
        .cfg    (cur_nxt),
        .hs_raw (hs_raw),
        .vs_raw (vs_raw),
        .vis    (vis),
        .act    (act),
        .ls     (ls)
    );

    always_comb begin
        out_d        = out_q;
        out_d.hsync  = ~(hs_raw ^ hs_pol);
        out_d.vsync  = ~(vs_raw ^ vs_pol);
        out_d.active = act;
        out_d.border = vis & ~act;
        out_d.blank  = ~vis;
        out_d.ls     = ls;
        if (ls) begin
            out_d.row = cur_nxt.row;
            out_d.col = cur_nxt.col;
        end
        if (rst) begin
            out_d        = '0;
            out_d.hsync  = ~hs_pol;
            out_d.vsync  = ~vs_pol;
            out_d.blank  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign hsync      = out_q.hsync;
    assign vsync      = out_q.vsync;
    assign blank      = out_q.blank;
    assign border     = out_q.border;
    assign active     = out_q.active;
    assign line_start = out_q.ls;
    assign ls_row     = out_q.row;
    assign ls_col     = out_q.col;

endmodule

// File: rtl/vtg_checks.sv
module vtg_checks
    import vtg_pkg::*;
#(
    parameter int H_TICKS = 420,
    parameter int HW      = 9,
    parameter int VW      = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          hs_pol,
    input logic          vs_pol,
    input logic          hsync,
    input logic          vsync,
    input logic          blank,
    input logic          active,
    input logic          line_start,
    input logic [HW-1:0] h_q,
    input logic [VW-1:0] v_q,
    input line_cfg_t     cur
);

    // R2
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_q == HW'(H_TICKS - 1)) |=> (h_q == '0));

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(h_q) < H_TICKS));

    // R2
    hsync_start_chk: assert property (@(posedge clk) disable iff (rst)
        (h_q == '0 && cur.sw != '0) |-> (hsync == $past(hs_pol)));

    // R4
    vsync_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync == $past(vs_pol)) |-> blank);

    // R6
    active_kind_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cur.kind == K_ACTIVE));

    // R7
    ls_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    // R10
    v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h_q != '0) |-> $stable(v_q));

endmodule

bind vtg_timing_gen vtg_checks #(.H_TICKS(H_TICKS), .HW(HW), .VW(VW)) u_vtg_checks (
    .clk        (clk),
    .rst        (rst),
    .hs_pol     (hs_pol),
    .vs_pol     (vs_pol),
    .hsync      (hsync),
    .vsync      (vsync),
    .blank      (blank),
    .active     (active),
    .line_start (line_start),
    .h_q        (h_cnt),
    .v_q        (v_cnt),
    .cur        (cur_cfg)
);

// File: tb/vtg_timing_gen_bench.sv
`timescale 1ns/1ps
module vtg_timing_gen_bench;
    import vtg_pkg::*;

    localparam int CLK_PERIOD = 42;
    localparam int H = 40;
    localparam int V = 8;
    localparam int AW = $clog2(V);

    typedef struct packed {
        logic       in_rst;
        logic       hs, vs, bl, bd, ac, ls;
        logic [9:0] row, col;
    } exp_t;

    logic clk = 1'b0;
    logic rst, hs_pol, vs_pol, wr_en;
    logic [AW-1:0] wr_addr;
    logic [CFG_W-1:0] wr_data;
    logic hsync, vsync, blank, border, active, line_start;
    logic [9:0] ls_row, ls_col;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t exp_q[$];
    logic [CFG_W-1:0] tbl [V];
    int m_h, m_v;
    logic [CFG_W-1:0] m_cur, m_fetch;
    logic [9:0] m_lr, m_lc;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtg_timing_gen #(.H_TICKS(H), .V_LINES(V)) u_vtg_timing_gen (
        .clk(clk), .rst(rst), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .blank(blank), .border(border),
        .active(active), .line_start(line_start), .ls_row(ls_row), .ls_col(ls_col)
    );

    // entry packing per R9
    function automatic logic [CFG_W-1:0] mk(int kind, int sw, int bp, int lb, int rb, int fp, int col, int row);
        return {10'(row), 10'(col), 6'(fp), 6'(rb), 6'(lb), 6'(bp), 6'(sw), 2'(kind)};
    endfunction

    // driver side of the scoreboard: expected outputs for one cycle
    task automatic push_exp(input bit in_rst, input int h, input logic [CFG_W-1:0] c, input logic hp, input logic vp);
        exp_t e;
        int kind, sw, bp, lb, rb, fp, vlo, vhi, alo, ahi;
        bit vis, act;
        e = '0;
        e.in_rst = in_rst;
        if (in_rst) begin
            e.hs = ~hp; e.vs = ~vp; e.bl = 1'b1;
        end else begin
            kind = int'(c[1:0]);   sw = int'(c[7:2]);   bp = int'(c[13:8]);
            lb   = int'(c[19:14]); rb = int'(c[25:20]); fp = int'(c[31:26]);
            vlo = sw + bp; vhi = H - fp; alo = vlo + lb; ahi = vhi - rb;
            vis = (kind >= 2) && (h >= vlo) && (h < vhi);
            act = (kind == 3) && (h >= alo) && (h < ahi);
            e.hs = (h < sw) ? hp : ~hp;
            e.vs = (kind == 1) ? vp : ~vp;
            e.ac = act;
            e.bd = vis && !act;
            e.bl = !vis;
            e.ls = (kind == 3) && (alo > 0) && (h == alo - 1);
            if (e.ls) begin
                m_lr = c[51:42];
                m_lc = c[41:32];
            end
        end
        e.row = m_lr;
        e.col = m_lc;
        exp_q.push_back(e);
    endtask

    // reference model of line/tick position, follows R1, R2, R9, R10
    always @(posedge clk) begin
        if (rst) begin
            m_h = 0; m_v = V - 1; m_cur = '0; m_lr = '0; m_lc = '0;
            push_exp(1'b1, 0, '0, hs_pol, vs_pol);
        end else begin
            if (m_h == H - 2) m_fetch = tbl[(m_v == V - 1) ? 0 : m_v + 1];
            if (m_h == H - 1) begin
                m_h = 0;
                m_v = (m_v == V - 1) ? 0 : m_v + 1;
                m_cur = m_fetch;
            end else begin
                m_h = m_h + 1;
            end
            push_exp(1'b0, m_h, m_cur, hs_pol, vs_pol);
        end
        if (wr_en) tbl[wr_addr] = wr_data;
    end

    task automatic chk(input string tag, input string what, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s at line %0d tick %0d: got %0d expected %0d", tag, what, m_v, m_h, got, expv);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            if (e.in_rst) begin
                chk("R1", "hsync", int'(hsync), int'(e.hs));
                chk("R1", "vsync", int'(vsync), int'(e.vs));
                chk("R1", "blank", int'(blank), 1);
                chk("R1", "border", int'(border), 0);
                chk("R1", "active", int'(active), 0);
                chk("R1", "line_start", int'(line_start), 0);
                chk("R1", "ls_row", int'(ls_row), 0);
                chk("R1", "ls_col", int'(ls_col), 0);
            end else begin
                chk("R2 R3", "hsync", int'(hsync), int'(e.hs));
                chk("R3 R4", "vsync", int'(vsync), int'(e.vs));
                chk("R4 R5", "blank", int'(blank), int'(e.bl));
                chk("R5 R6", "border", int'(border), int'(e.bd));
                chk("R6 R9", "active", int'(active), int'(e.ac));
                chk("R7", "line_start", int'(line_start), int'(e.ls));
                chk("R8 R10", "ls_row", int'(ls_row), int'(e.row));
                chk("R8 R10", "ls_col", int'(ls_col), int'(e.col));
            end
        end
    end

    task automatic write_entry(input int addr, input logic [CFG_W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_pos(input int line, input int tick);
        do begin
            @(posedge clk); #1;
        end while (!(m_v == line && m_h == tick));
    endtask

    initial begin
        rst = 1'b1; hs_pol = 1'b1; vs_pol = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (2) @(posedge clk);
        // R9: table filled while reset is held
        write_entry(0, mk(1, 4, 2, 0, 0, 2, 0, 0));
        write_entry(1, mk(0, 4, 3, 0, 0, 2, 0, 0));
        write_entry(2, mk(2, 4, 3, 2, 2, 3, 0, 0));
        write_entry(3, mk(3, 4, 3, 2, 2, 3, 5, 100));
        write_entry(4, mk(3, 3, 2, 0, 5, 1, 17, 513));
        write_entry(5, mk(3, 0, 0, 0, 0, 0, 300, 2));
        write_entry(6, mk(3, 5, 4, 6, 1, 6, 1023, 1023));
        write_entry(7, mk(2, 4, 1, 0, 0, 0, 0, 0));
        repeat (2) @(posedge clk); #1;
        rst = 1'b0;
        // R10: mid-frame rewrite of a line two ahead
        wait_pos(1, 10);
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = mk(3, 6, 1, 3, 4, 2, 9, 7);
        @(posedge clk); #1; wr_en = 1'b0;
        // R3: polarity flips mid-frame
        wait_pos(4, 7);
        hs_pol = 1'b0; vs_pol = 1'b1;
        // R10: write lands on the fetch edge of the next line; old entry must be used
        wait_pos(5, H - 2);
        wr_en = 1'b1; wr_addr = AW'(6); wr_data = mk(2, 2, 2, 0, 0, 4, 0, 0);
        @(posedge clk); #1; wr_en = 1'b0;
        wait_pos(2, 3);
        hs_pol = 1'b1;
        repeat (3 * H * V) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule